// File: doc/BRIEF.md
# Energy-Detection Receiver Phase Sequencer

This block is the control state machine of a pulse-based radio receiver that decides on the presence of pulses by measuring signal energy. The receiver squares the input, integrates it and dumps it into a converter once per integration window. The sequencer takes those converter samples and groups a fixed number of them into one bit period. It uses the bit-period totals and peaks to drive the acquisition steps in order.

After reset the sequencer measures the noise energy of one bit period and stores that total, plus a programmable margin, as the detection threshold. It then watches the channel one bit period at a time. When a bit period's energy rises above the threshold, it tunes a 4-bit amplifier gain code until the peak sample is neither clipped nor too small. It then enables the coarse synchronizer. When the synchronizer reports lock, demodulation and fine synchronization are enabled together until the end of the frame. If a ranging request arrives during the frame, a single-cycle reply strobe is issued at frame end, carrying the captured coarse and fine timing offsets. If lock does not arrive in time, the sequencer goes back to listening. Transmission of the reply is handled elsewhere.

Top module: `edr_sequencer`

## Requirements
- R1: After reset, `cal_en` is 1, `gain_code` is 8 and `threshold` is 0. When the first full bit period of SPB valid samples completes, `threshold` becomes the sum of those samples plus `margin`, and `listen_en` rises. `threshold` changes at no other time.
- R2: While listening, a bit period whose sample sum is less than or equal to `threshold` keeps `listen_en` high. A sum strictly above `threshold` moves the block to gain tuning (`gain_en`).
- R3: During gain tuning, each completed bit period is judged by its peak sample. A peak of 15 (full scale) lowers `gain_code` by one, floored at 0. A peak below 8 (half scale) raises it by one, capped at 15. A peak from 8 to 14 leaves the code unchanged and enables coarse synchronization (`coarse_en`).
- R4: `gain_code` changes only while `gain_en` is high, and by at most one step per change.
- R5: After 16 gain evaluations without an in-range peak, the block enables coarse synchronization anyway.
- R6: A `coarse_lock` pulse during coarse synchronization raises both `demod_en` and `fine_en` on the next cycle, and `reply_coarse` captures `coarse_off`.
- R7: If no lock arrives within COARSE_TMO cycles (64 by default) of entering coarse synchronization, the block returns to listening.
- R8: A `rng_cmd` pulse during demodulation arms a reply. The next `frame_end` then produces a `reply_go` pulse of exactly one cycle, with `reply_fine` holding the `fine_off` value sampled at `frame_end`. Listening resumes on the following cycle.
- R9: `frame_end` without an armed reply returns to listening with no `reply_go`. A `rng_cmd` outside demodulation has no effect.
- R10: Exactly one of `cal_en`, `listen_en`, `gain_en`, `coarse_en`, `demod_en`, `reply_go` is high in every cycle; `fine_en` equals `demod_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Converter sample present this cycle |
| smp | input | SMP_W (4) | Integrated-energy converter sample |
| margin | input | ACC_W (6) | Margin added to the measured noise energy |
| coarse_lock | input | 1 | Coarse synchronizer reports lock |
| coarse_off | input | OFS_W (8) | Coarse timing offset from the synchronizer |
| frame_end | input | 1 | Demodulator reports end of frame |
| fine_off | input | OFS_W (8) | Fine timing offset from the fine synchronizer |
| rng_cmd | input | 1 | Ranging request decoded from the frame |
| gain_code | output | GAIN_W (4) | Amplifier gain step |
| threshold | output | ACC_W+1 (7) | Detection threshold |
| cal_en | output | 1 | Noise calibration phase |
| listen_en | output | 1 | Channel listening phase |
| gain_en | output | 1 | Gain tuning phase |
| coarse_en | output | 1 | Coarse synchronizer enable |
| demod_en | output | 1 | Demodulator enable |
| fine_en | output | 1 | Fine synchronizer enable |
| reply_go | output | 1 | One-cycle strobe to launch the ranging reply |
| reply_coarse | output | OFS_W (8) | Coarse offset captured at lock |
| reply_fine | output | OFS_W (8) | Fine offset captured at frame end |

## Verification
The cycle-by-cycle properties cover the following: the phase outputs are mutually exclusive, the threshold is frozen outside calibration, the gain code is frozen outside tuning and never jumps more than one step, lock is followed by concurrent demodulation and fine synchronization, and the reply strobe lasts one cycle before listening resumes. Only the directed scenarios can show the arithmetic and ordering results. These are the exact threshold value, the equal-to-threshold boundary that must not trigger, the direction of each gain step with its floor, the 16-attempt cap, the 64-cycle lock timeout, the captured offsets, and the fact that a stray ranging request outside a frame arms nothing.

// File: rtl/edr_pkg.sv
package edr_pkg;

    typedef enum logic [2:0] {
        ST_CAL    = 3'd0,
        ST_LISTEN = 3'd1,
        ST_GAIN   = 3'd2,
        ST_COARSE = 3'd3,
        ST_DEMOD  = 3'd4,
        ST_REPLY  = 3'd5
    } edr_state_e;

endpackage

// File: rtl/edr_bit_energy.sv
// Groups SPB valid samples into one bit period; reports total and peak.
module edr_bit_energy #(
    parameter int SMP_W = 4,
    parameter int SPB   = 4,
    localparam int ACC_W = SMP_W + $clog2(SPB),
    localparam int CNT_W = (SPB > 1) ? $clog2(SPB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp,
    output logic             bit_done,
    output logic [ACC_W-1:0] bit_sum,
    output logic [SMP_W-1:0] bit_peak
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] sum;
        logic [SMP_W-1:0] peak;
        logic [ACC_W-1:0] out_sum;
        logic [SMP_W-1:0] out_peak;
        logic             done;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        logic [ACC_W-1:0] s;
        logic [SMP_W-1:0] p;
        acc_d      = acc_q;
        acc_d.done = 1'b0;
        s = acc_q.sum + ACC_W'(smp);
        p = (smp > acc_q.peak) ? smp : acc_q.peak;
        if (smp_valid) begin
            if (acc_q.cnt == CNT_W'(SPB - 1)) begin
                acc_d.out_sum  = s;
                acc_d.out_peak = p;
                acc_d.done     = 1'b1;
                acc_d.cnt      = '0;
                acc_d.sum      = '0;
                acc_d.peak     = '0;
            end else begin
                acc_d.cnt  = acc_q.cnt + 1'b1;
                acc_d.sum  = s;
                acc_d.peak = p;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign bit_done = acc_q.done;
    assign bit_sum  = acc_q.out_sum;
    assign bit_peak = acc_q.out_peak;

endmodule

// File: rtl/edr_ctrl.sv
// Phase state machine: calibration, listening, gain tuning, lock, frame.
module edr_ctrl
    import edr_pkg::*;
#(
    parameter int SMP_W      = 4,
    parameter int ACC_W      = 6,
    parameter int GAIN_W     = 4,
    parameter int GAIN_INIT  = 8,
    parameter int MAX_TRIES  = 16,
    parameter int COARSE_TMO = 64,
    parameter int OFS_W      = 8,
    localparam int THR_W = ACC_W + 1,
    localparam int TRY_W = $clog2(MAX_TRIES + 1),
    localparam int TMO_W = (COARSE_TMO > 1) ? $clog2(COARSE_TMO) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_done,
    input  logic [ACC_W-1:0]  bit_sum,
    input  logic [SMP_W-1:0]  bit_peak,
    input  logic [ACC_W-1:0]  margin,
    input  logic              coarse_lock,
    input  logic [OFS_W-1:0]  coarse_off,
    input  logic              frame_end,
    input  logic [OFS_W-1:0]  fine_off,
    input  logic              rng_cmd,
    output edr_state_e        state,
    output logic [GAIN_W-1:0] gain_code,
    output logic [THR_W-1:0]  threshold,
    output logic [OFS_W-1:0]  reply_coarse,
    output logic [OFS_W-1:0]  reply_fine
);

    localparam logic [SMP_W-1:0] FULL = '1;
    localparam logic [SMP_W-1:0] HALF = {1'b1, {(SMP_W-1){1'b0}}};

    typedef struct packed {
        edr_state_e        st;
        logic [GAIN_W-1:0] gain;
        logic [THR_W-1:0]  thr;
        logic [TRY_W-1:0]  tries;
        logic [TMO_W-1:0]  tmo;
        logic              armed;
        logic [OFS_W-1:0]  rc;
        logic [OFS_W-1:0]  rf;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        logic in_range;
        c_d      = c_q;
        in_range = 1'b0;
        unique case (c_q.st)
            ST_CAL: begin
                if (bit_done) begin
                    c_d.thr = THR_W'(bit_sum) + THR_W'(margin);
                    c_d.st  = ST_LISTEN;
                end
            end
            ST_LISTEN: begin
                if (bit_done && (THR_W'(bit_sum) > c_q.thr)) begin
                    c_d.st    = ST_GAIN;
                    c_d.tries = '0;
                end
            end
            ST_GAIN: begin
                if (bit_done) begin
                    if (bit_peak == FULL) begin
                        if (c_q.gain != '0) c_d.gain = c_q.gain - 1'b1;
                    end else if (bit_peak < HALF) begin
                        if (c_q.gain != '1) c_d.gain = c_q.gain + 1'b1;
                    end else begin
                        in_range = 1'b1;
                    end
                    c_d.tries = c_q.tries + 1'b1;
                    if (in_range || (c_q.tries == TRY_W'(MAX_TRIES - 1))) begin
                        c_d.st  = ST_COARSE;
                        c_d.tmo = '0;
                    end
                end
            end
            ST_COARSE: begin
                if (coarse_lock) begin
                    c_d.st    = ST_DEMOD;
                    c_d.rc    = coarse_off;
                    c_d.armed = 1'b0;
                end else if (c_q.tmo == TMO_W'(COARSE_TMO - 1)) begin
                    c_d.st = ST_LISTEN;
                end else begin
                    c_d.tmo = c_q.tmo + 1'b1;
                end
            end
            ST_DEMOD: begin
                if (rng_cmd) c_d.armed = 1'b1;
                if (frame_end) begin
                    c_d.rf = fine_off;
                    c_d.st = (c_q.armed || rng_cmd) ? ST_REPLY : ST_LISTEN;
                end
            end
            ST_REPLY: begin
                c_d.st    = ST_LISTEN;
                c_d.armed = 1'b0;
            end
            default: c_d.st = ST_CAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= ST_CAL;
            c_q.gain  <= GAIN_W'(GAIN_INIT);
            c_q.thr   <= '0;
            c_q.tries <= '0;
            c_q.tmo   <= '0;
            c_q.armed <= 1'b0;
            c_q.rc    <= '0;
            c_q.rf    <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign state        = c_q.st;
    assign gain_code    = c_q.gain;
    assign threshold    = c_q.thr;
    assign reply_coarse = c_q.rc;
    assign reply_fine   = c_q.rf;

endmodule

// File: rtl/edr_sequencer.sv
module edr_sequencer
    import edr_pkg::*;
#(
    parameter int SMP_W      = 4,
    parameter int SPB        = 4,
    parameter int GAIN_W     = 4,
    parameter int GAIN_INIT  = 8,
    parameter int MAX_TRIES  = 16,
    parameter int COARSE_TMO = 64,
    parameter int OFS_W      = 8,
    localparam int ACC_W = SMP_W + $clog2(SPB),
    localparam int THR_W = ACC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp,
    input  logic [ACC_W-1:0]  margin,
    input  logic              coarse_lock,
    input  logic [OFS_W-1:0]  coarse_off,
    input  logic              frame_end,
    input  logic [OFS_W-1:0]  fine_off,
    input  logic              rng_cmd,
    output logic [GAIN_W-1:0] gain_code,
    output logic [THR_W-1:0]  threshold,
    output logic              cal_en,
    output logic              listen_en,
    output logic              gain_en,
    output logic              coarse_en,
    output logic              demod_en,
    output logic              fine_en,
    output logic              reply_go,
    output logic [OFS_W-1:0]  reply_coarse,
    output logic [OFS_W-1:0]  reply_fine
);

    logic             bit_done;
    logic [ACC_W-1:0] bit_sum;
    logic [SMP_W-1:0] bit_peak;
    edr_state_e       state;

    edr_bit_energy #(
        .SMP_W (SMP_W),
        .SPB   (SPB)
    ) u_energy (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp       (smp),
        .bit_done  (bit_done),
        .bit_sum   (bit_sum),
        .bit_peak  (bit_peak)
    );

    edr_ctrl #(
        .SMP_W      (SMP_W),
        .ACC_W      (ACC_W),
        .GAIN_W     (GAIN_W),
        .GAIN_INIT  (GAIN_INIT),
        .MAX_TRIES  (MAX_TRIES),
        .COARSE_TMO (COARSE_TMO),
        .OFS_W      (OFS_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_done     (bit_done),
        .bit_sum      (bit_sum),
        .bit_peak     (bit_peak),
        .margin       (margin),
        .coarse_lock  (coarse_lock),
        .coarse_off   (coarse_off),
        .frame_end    (frame_end),
        .fine_off     (fine_off),
        .rng_cmd      (rng_cmd),
        .state        (state),
        .gain_code    (gain_code),
        .threshold    (threshold),
        .reply_coarse (reply_coarse),
        .reply_fine   (reply_fine)
    );

    always_comb begin
        cal_en    = (state == ST_CAL);
        listen_en = (state == ST_LISTEN);
        gain_en   = (state == ST_GAIN);
        coarse_en = (state == ST_COARSE);
        demod_en  = (state == ST_DEMOD);
        fine_en   = (state == ST_DEMOD);
        reply_go  = (state == ST_REPLY);
    end

endmodule

// File: rtl/edr_seq_checker.sv
module edr_seq_checker #(
    parameter int GAIN_W = 4,
    parameter int THR_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              coarse_lock,
    input logic              cal_en,
    input logic              listen_en,
    input logic              gain_en,
    input logic              coarse_en,
    input logic              demod_en,
    input logic              fine_en,
    input logic              reply_go,
    input logic [GAIN_W-1:0] gain_code,
    input logic [THR_W-1:0]  threshold
);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cal_en, listen_en, gain_en, coarse_en, demod_en, reply_go}) == 1); // R10

    AST_THR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> $stable(threshold)); // R1

    AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_en |=> $stable(gain_code)); // R4

    AST_GAIN_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        gain_en |=> ((gain_code == $past(gain_code)) ||
                     (gain_code == GAIN_W'($past(gain_code) + 1'b1)) ||
                     (gain_code == GAIN_W'($past(gain_code) - 1'b1)))); // R4

    AST_LOCK_TO_DEMOD: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_en && coarse_lock) |=> (demod_en && fine_en)); // R6

    AST_REPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reply_go |=> (listen_en && !reply_go)); // R8

endmodule

bind edr_sequencer edr_seq_checker #(
    .GAIN_W (GAIN_W),
    .THR_W  (THR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .coarse_lock (coarse_lock),
    .cal_en      (cal_en),
    .listen_en   (listen_en),
    .gain_en     (gain_en),
    .coarse_en   (coarse_en),
    .demod_en    (demod_en),
    .fine_en     (fine_en),
    .reply_go    (reply_go),
    .gain_code   (gain_code),
    .threshold   (threshold)
);

// File: tb/sim_edr_sequencer.sv
`timescale 1ns/1ps
module sim_edr_sequencer;

    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [3:0] smp = '0;
    logic [5:0] margin = 6'd5;
    logic       coarse_lock = 1'b0;
    logic [7:0] coarse_off = '0;
    logic       frame_end = 1'b0;
    logic [7:0] fine_off = '0;
    logic       rng_cmd = 1'b0;
    logic [3:0] gain_code;
    logic [6:0] threshold;
    logic       cal_en, listen_en, gain_en, coarse_en, demod_en, fine_en, reply_go;
    logic [7:0] reply_coarse, reply_fine;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    edr_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp), .margin(margin),
        .coarse_lock(coarse_lock), .coarse_off(coarse_off), .frame_end(frame_end),
        .fine_off(fine_off), .rng_cmd(rng_cmd), .gain_code(gain_code),
        .threshold(threshold), .cal_en(cal_en), .listen_en(listen_en),
        .gain_en(gain_en), .coarse_en(coarse_en), .demod_en(demod_en),
        .fine_en(fine_en), .reply_go(reply_go), .reply_coarse(reply_coarse),
        .reply_fine(reply_fine)
    );

    // Gain table: {peak, other samples, expected gain, expected gain_en}
    localparam logic [12:0] GVEC [0:4] = '{
        {4'd15, 4'd1,  4'd7, 1'b1},
        {4'd15, 4'd15, 4'd6, 1'b1},
        {4'd3,  4'd3,  4'd7, 1'b1},
        {4'd7,  4'd0,  4'd8, 1'b1},
        {4'd8,  4'd2,  4'd8, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One bit period: first sample pk, the rest rs; returns after the FSM edge.
    task automatic send_bit(input logic [3:0] pk, input logic [3:0] rs);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp = (i == 0) ? pk : rs;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic lock(input logic [7:0] ofs);
        @(negedge clk); @(negedge clk);
        coarse_lock = 1'b1;
        coarse_off  = ofs;
        @(negedge clk);
        coarse_lock = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cal_en at reset", cal_en, 1);
        chk("R1 gain at reset", gain_code, 8);
        chk("R1 threshold at reset", threshold, 0);
        chk("R10 one phase", cal_en + listen_en + gain_en + coarse_en + demod_en + reply_go, 1);

        send_bit(4'd2, 4'd2);                  // sum 8, margin 5
        chk("R1 threshold", threshold, 13);
        chk("R1 listen after cal", listen_en, 1);

        rng_cmd = 1'b1; @(negedge clk); rng_cmd = 1'b0;   // ignored (R9)
        send_bit(4'd4, 4'd3);                  // sum 13 == threshold
        chk("R2 equal stays", listen_en, 1);
        send_bit(4'd5, 4'd3);                  // sum 14
        chk("R2 above detects", gain_en, 1);
        chk("R1 threshold held", threshold, 13);

        for (int k = 0; k < 5; k++) begin
            send_bit(GVEC[k][12:9], GVEC[k][8:5]);
            chk("R3 gain step", gain_code, int'(GVEC[k][4:1]));
            chk("R3 gain_en", gain_en, int'(GVEC[k][0]));
        end
        chk("R3 in range to coarse", coarse_en, 1);

        // Demodulation after rng_cmd pulse outside frame: no reply (R9)
        lock(8'h2A);
        chk("R6 demod_en", demod_en, 1);
        chk("R6 fine_en", fine_en, 1);
        chk("R6 coarse offset", reply_coarse, 8'h2A);
        frame_end = 1'b1; fine_off = 8'h05;
        @(negedge clk);
        frame_end = 1'b0;
        chk("R9 no reply", reply_go, 0);
        chk("R9 back to listen", listen_en, 1);

        // Ranging frame
        send_bit(4'd15, 4'd15);
        chk("R2 detect", gain_en, 1);
        send_bit(4'd9, 4'd9);
        chk("R3 in range", coarse_en, 1);
        lock(8'h33);
        rng_cmd = 1'b1; @(negedge clk); rng_cmd = 1'b0;
        @(negedge clk);
        chk("R8 armed stays demod", demod_en, 1);
        frame_end = 1'b1; fine_off = 8'h13;
        @(negedge clk);
        frame_end = 1'b0;
        chk("R8 reply_go", reply_go, 1);
        chk("R8 reply_fine", reply_fine, 8'h13);
        chk("R8 reply_coarse", reply_coarse, 8'h33);
        @(negedge clk);
        chk("R8 pulse ends", reply_go, 0);
        chk("R8 listen after reply", listen_en, 1);

        // Lock timeout
        send_bit(4'd15, 4'd15);
        send_bit(4'd10, 4'd10);
        chk("R3 enter coarse", coarse_en, 1);
        repeat (TMO - 1) @(negedge clk);
        chk("R7 still coarse", coarse_en, 1);
        @(negedge clk);
        chk("R7 timeout to listen", listen_en, 1);

        // Attempt cap and floor at zero
        send_bit(4'd15, 4'd15);
        chk("R2 detect again", gain_en, 1);
        for (int k = 1; k <= 16; k++) begin
            send_bit(4'd15, 4'd15);
            if (k == 9) begin
                chk("R3 floor at 0", gain_code, 0);
                chk("R5 still tuning", gain_en, 1);
            end
            if (k == 15) chk("R5 tuning at 15", gain_en, 1);
        end
        chk("R5 cap to coarse", coarse_en, 1);
        chk("R4 gain held", gain_code, 0);
        repeat (5) @(negedge clk);
        chk("R4 gain frozen in coarse", gain_code, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule